// File: doc/BRIEF.md
# Power-Up and Reset Sequencer

This block turns a board power-good level and an active-low platform reset into a fixed sequence of outputs. The outputs are a strap sample enable with a captured strap word, a power-on configuration drive enable, an active-low processor reset, an array-initialization busy flag and a one-cycle reset-done capture pulse. Bus clock and core clock are one domain, so every delay is a count of `clk` cycles, and each count is a parameter. A bench can shrink the long delays while the defaults keep full-length values.

Both control inputs pass through a multi-flop synchronizer. Power-good also acts as the asynchronous clear of the whole block. A drop on it returns every output and counter to its idle value at once, whatever state the sequencer is in. After power-good rises, the straps are captured and the configuration drive comes up. The processor reset then follows the platform reset. Its release is delayed by a long setup count and gated by a link-ready input. The configuration drive is held a few cycles past the release edge. A platform reset assertion that comes too soon after the previous release is ignored.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `pwr_ok_i` is low, the outputs are held at their idle values, and they take those values in the same time step the input falls: `strap_en_o`=1, `strap_q_o`=0, `cfg_drv_o`=0, `cpu_rst_n_o`=0, `arr_busy_o`=0, `done_pulse_o`=0.
- R2: A rising `pwr_ok_i` or `plat_rst_n_i` first affects the outputs on clock edge SYNC_STAGES+1 after the input changes.
- R3: On the edge where power-good takes effect, `strap_q_o` captures `strap_i` and `strap_en_o` drops to 0. Later changes of `strap_i` have no effect on `strap_q_o` until power-good is lost.
- R4: `cfg_drv_o` rises exactly CFG_DLY clocks after `strap_en_o` drops, while `cpu_rst_n_o` stays 0.
- R5: When the platform reset release takes effect, setup starts. `cpu_rst_n_o` stays 0 for at least SETUP_CNT clocks from that edge.
- R6: `cpu_rst_n_o` rises on the first edge at which the setup count has elapsed and `link_done_i` is 1. While `link_done_i` is 0, it stays low.
- R7: `arr_busy_o` is 1 for exactly ARR_CNT clocks, starting on the edge where setup starts.
- R8: `cfg_drv_o` stays 1 for exactly CFG_HOLD clocks after `cpu_rst_n_o` rises, then falls. CFG_HOLD must lie in 2..19.
- R9: `done_pulse_o` is high for exactly one clock, DONE_CNT clocks after `cpu_rst_n_o` rises.
- R10: A platform reset assertion driven RETRIG or more clocks after the previous release is accepted. It takes effect SYNC_STAGES+1 edges later: `cpu_rst_n_o` falls and `cfg_drv_o` is 1 in that same cycle, and `arr_busy_o` ends if setup was running. The sequencer then waits for a new release.
- R11: A platform reset assertion driven fewer than RETRIG clocks after the previous release is ignored, and the rest of the sequence keeps its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and core timing |
| pwr_ok_i | input | 1 | Power-good level; low clears the whole block asynchronously |
| plat_rst_n_i | input | 1 | Active-low platform reset request |
| link_done_i | input | 1 | Serial-link initialization finished |
| strap_i | input | STRAP_W | Strap pins sampled at power-good |
| strap_en_o | output | 1 | Strap sampling open (1) or held (0) |
| strap_q_o | output | STRAP_W | Captured strap word |
| cfg_drv_o | output | 1 | Power-on configuration drive enable |
| cpu_rst_n_o | output | 1 | Active-low processor reset |
| arr_busy_o | output | 1 | Array initialization in progress |
| done_pulse_o | output | 1 | One-cycle reset-done capture strobe |

## Verification
Two functions can fall in the same cycle. The first pair is lockout expiry and acceptance of a new platform reset assertion. The bench drives one assertion at RETRIG-1 clocks after release, which must leave the release time unchanged. It drives another at exactly RETRIG clocks, which must end `arr_busy_o` early and keep the processor in reset. The second pair is the processor reset falling edge and the configuration drive enable. An accepted re-trigger during the run phase must show both changing on the same recorded cycle. That cycle is predicted from the input drive time plus the synchronizer latency.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_PGWAIT = 3'd1,
      ST_HOLD   = 3'd2,
      ST_SETUP  = 3'd3,
      ST_RUN    = 3'd4
   } rsq_state_e;

   function automatic int rsq_max3(int a, int b, int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) chain[gi] <= 1'b0;
               else         chain[gi] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) chain[gi] <= 1'b0;
               else         chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rsq_lockout.sv
module rsq_lockout #(
   parameter int RETRIG = 50
) (
   input  logic clk,
   input  logic arst_n,
   input  logic start,
   output logic ok
);

   localparam int            LW   = (RETRIG > 2) ? $clog2(RETRIG) : 1;
   localparam logic [LW-1:0] LAST = LW'(RETRIG - 1);

   logic [LW-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)          cnt <= '0;
      else if (start)       cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign ok = (cnt == LAST);

   // R11: a window that was just opened cannot already be expired
   p_window_closed_r11: assert property (@(posedge clk) disable iff (!arst_n)
      start |=> !ok);

endmodule

// File: rtl/rsq_core.sv
module rsq_core
   import rsq_pkg::*;
#(
   parameter int STRAP_W   = 8,
   parameter int CFG_DLY   = 2,
   parameter int SETUP_CNT = 162000,
   parameter int ARR_CNT   = 200,
   parameter int CFG_HOLD  = 8,
   parameter int DONE_CNT  = 2000
) (
   input  logic               clk,
   input  logic               arst_n,
   input  logic               pg_s,
   input  logic               plat_s,
   input  logic               link_done,
   input  logic               lock_ok,
   input  logic [STRAP_W-1:0] strap_in,
   output logic               lock_start,
   output logic               strap_en,
   output logic [STRAP_W-1:0] strap_q,
   output logic               cfg_drv,
   output logic               cpu_rst_n,
   output logic               arr_busy,
   output logic               done_pulse
);

   localparam int            CNT_TOP  = rsq_max3(SETUP_CNT, DONE_CNT + 1, CFG_DLY);
   localparam int            CW       = $clog2(CNT_TOP + 1);
   localparam logic [CW-1:0] K_DLY    = CW'(CFG_DLY - 1);
   localparam logic [CW-1:0] K_SETUP  = CW'(SETUP_CNT - 1);
   localparam logic [CW-1:0] K_ARR    = CW'(ARR_CNT);
   localparam logic [CW-1:0] K_HOLD   = CW'(CFG_HOLD);
   localparam logic [CW-1:0] K_DONE   = CW'(DONE_CNT);
   localparam logic [CW-1:0] K_SAT    = CW'(DONE_CNT + 1);

   rsq_state_e    st, st_nx;
   logic [CW-1:0] cnt, cnt_nx;
   logic          plat_d;
   logic          retrig;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st      <= ST_OFF;
         cnt     <= '0;
         plat_d  <= 1'b0;
         strap_q <= '0;
      end else begin
         st     <= st_nx;
         cnt    <= cnt_nx;
         plat_d <= plat_s;
         if (st == ST_OFF && pg_s) strap_q <= strap_in;
      end
   end

   // accepted only once the lockout window has run out
   assign retrig = plat_d & ~plat_s & lock_ok;

   always_comb begin
      st_nx  = st;
      cnt_nx = cnt;
      unique case (st)
         ST_OFF: begin
            if (pg_s) begin
               st_nx  = ST_PGWAIT;
               cnt_nx = '0;
            end
         end
         ST_PGWAIT: begin
            if (cnt == K_DLY) begin
               st_nx  = ST_HOLD;
               cnt_nx = '0;
            end else begin
               cnt_nx = cnt + 1'b1;
            end
         end
         ST_HOLD: begin
            if (plat_s) begin
               st_nx  = ST_SETUP;
               cnt_nx = '0;
            end
         end
         ST_SETUP: begin
            if (retrig) begin
               st_nx  = ST_HOLD;
               cnt_nx = '0;
            end else if (cnt == K_SETUP && link_done) begin
               st_nx  = ST_RUN;
               cnt_nx = '0;
            end else if (cnt != K_SETUP) begin
               cnt_nx = cnt + 1'b1;
            end
         end
         ST_RUN: begin
            if (retrig) begin
               st_nx  = ST_HOLD;
               cnt_nx = '0;
            end else if (cnt != K_SAT) begin
               cnt_nx = cnt + 1'b1;
            end
         end
         default: begin
            st_nx  = ST_OFF;
            cnt_nx = '0;
         end
      endcase
   end

   assign lock_start = (st == ST_HOLD) && plat_s;
   assign strap_en   = (st == ST_OFF);
   assign cfg_drv    = (st == ST_HOLD) || (st == ST_SETUP) ||
                       ((st == ST_RUN) && (cnt < K_HOLD));
   assign cpu_rst_n  = (st == ST_RUN);
   assign arr_busy   = (st == ST_SETUP) && (cnt < K_ARR);
   assign done_pulse = (st == ST_RUN) && (cnt == K_DONE);

   // R10: configuration drive is already on when the processor enters reset
   p_drive_at_reset_r10: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(cpu_rst_n) |-> cfg_drv);

   // R10: a reset re-entry is only possible after the lockout expired
   p_reentry_unlocked_r10: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(cpu_rst_n) |-> $past(lock_ok));

   // R8: drive is held at least one more cycle past the release edge
   p_drive_hold_r8: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(cpu_rst_n) |=> (cfg_drv || !cpu_rst_n));

   // R9: the done strobe lasts a single cycle
   p_done_single_r9: assert property (@(posedge clk) disable iff (!arst_n)
      done_pulse |=> !done_pulse);

   // R7: array initialization only runs with the processor held in reset
   p_busy_in_reset_r7: assert property (@(posedge clk) disable iff (!arst_n)
      arr_busy |-> !cpu_rst_n);

   // R3: once sampling has closed, the captured straps never move
   p_strap_held_r3: assert property (@(posedge clk) disable iff (!arst_n)
      (!strap_en && $past(!strap_en)) |-> $stable(strap_q));

endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq #(
   parameter int STRAP_W     = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CFG_DLY     = 2,
   parameter int SETUP_CNT   = 162000,
   parameter int ARR_CNT     = 200,
   parameter int CFG_HOLD    = 8,
   parameter int DONE_CNT    = 2000,
   parameter int RETRIG      = 50
) (
   input  logic               clk,
   input  logic               pwr_ok_i,
   input  logic               plat_rst_n_i,
   input  logic               link_done_i,
   input  logic [STRAP_W-1:0] strap_i,
   output logic               strap_en_o,
   output logic [STRAP_W-1:0] strap_q_o,
   output logic               cfg_drv_o,
   output logic               cpu_rst_n_o,
   output logic               arr_busy_o,
   output logic               done_pulse_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CFG_DLY < 1) begin : g_bad_dly
         $error("CFG_DLY must be at least 1");
      end
      if (ARR_CNT < 1 || ARR_CNT >= SETUP_CNT) begin : g_bad_arr
         $error("ARR_CNT must be in 1..SETUP_CNT-1");
      end
      if (CFG_HOLD < 2 || CFG_HOLD > 19) begin : g_bad_hold
         $error("CFG_HOLD must be in 2..19");
      end
      if (DONE_CNT < 1) begin : g_bad_done
         $error("DONE_CNT must be at least 1");
      end
      if (RETRIG < 2) begin : g_bad_retrig
         $error("RETRIG must be at least 2");
      end
      if (STRAP_W < 1) begin : g_bad_strap
         $error("STRAP_W must be at least 1");
      end
   endgenerate

   logic pg_s, plat_s, lock_ok, lock_start;

   rsq_sync #(.STAGES(SYNC_STAGES)) u_sync_pg (
      .clk    (clk),
      .arst_n (pwr_ok_i),
      .d      (1'b1),
      .q      (pg_s)
   );

   rsq_sync #(.STAGES(SYNC_STAGES)) u_sync_plat (
      .clk    (clk),
      .arst_n (pwr_ok_i),
      .d      (plat_rst_n_i),
      .q      (plat_s)
   );

   rsq_lockout #(.RETRIG(RETRIG)) u_lock (
      .clk    (clk),
      .arst_n (pwr_ok_i),
      .start  (lock_start),
      .ok     (lock_ok)
   );

   rsq_core #(
      .STRAP_W   (STRAP_W),
      .CFG_DLY   (CFG_DLY),
      .SETUP_CNT (SETUP_CNT),
      .ARR_CNT   (ARR_CNT),
      .CFG_HOLD  (CFG_HOLD),
      .DONE_CNT  (DONE_CNT)
   ) u_core (
      .clk        (clk),
      .arst_n     (pwr_ok_i),
      .pg_s       (pg_s),
      .plat_s     (plat_s),
      .link_done  (link_done_i),
      .lock_ok    (lock_ok),
      .strap_in   (strap_i),
      .lock_start (lock_start),
      .strap_en   (strap_en_o),
      .strap_q    (strap_q_o),
      .cfg_drv    (cfg_drv_o),
      .cpu_rst_n  (cpu_rst_n_o),
      .arr_busy   (arr_busy_o),
      .done_pulse (done_pulse_o)
   );

   // R1: a cleared block shows processor reset asserted right after release
   p_idle_after_clear_r1: assert property (@(posedge clk) disable iff (!pwr_ok_i)
      (strap_en_o && $past(strap_en_o)) |-> (!cpu_rst_n_o && !cfg_drv_o));

endmodule

// File: tb/tb_pwr_rst_seq.sv
`timescale 1ns/1ps
module tb_pwr_rst_seq;

   localparam int W      = 8;
   localparam int SYNC   = 2;
   localparam int LAT    = SYNC + 1;
   localparam int DLY    = 2;
   localparam int SETUP  = 300;
   localparam int ARR    = 120;
   localparam int HOLD   = 6;
   localparam int DONE   = 40;
   localparam int RETRIG = 50;

   logic         clk = 1'b0;
   logic         pwr_ok_i = 1'b0, plat_rst_n_i = 1'b0, link_done_i = 1'b0;
   logic [W-1:0] strap_i = '0;
   logic         strap_en_o, cfg_drv_o, cpu_rst_n_o, arr_busy_o, done_pulse_o;
   logic [W-1:0] strap_q_o;

   int cyc = 0, tests = 0, fails = 0;
   bit finished = 0;
   int t_strap_fall, t_cfg_rise, t_cfg_fall, t_cpu_rise, t_cpu_fall;
   int t_arr_rise, t_arr_fall, t_done, n_done;
   logic p_strap = 1, p_cfg = 0, p_cpu = 0, p_arr = 0;

   pwr_rst_seq #(
      .STRAP_W(W), .SYNC_STAGES(SYNC), .CFG_DLY(DLY), .SETUP_CNT(SETUP),
      .ARR_CNT(ARR), .CFG_HOLD(HOLD), .DONE_CNT(DONE), .RETRIG(RETRIG)
   ) dut (
      .clk(clk), .pwr_ok_i(pwr_ok_i), .plat_rst_n_i(plat_rst_n_i),
      .link_done_i(link_done_i), .strap_i(strap_i), .strap_en_o(strap_en_o),
      .strap_q_o(strap_q_o), .cfg_drv_o(cfg_drv_o), .cpu_rst_n_o(cpu_rst_n_o),
      .arr_busy_o(arr_busy_o), .done_pulse_o(done_pulse_o)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // edge recorder: samples 2 ns after each rising edge
   always @(posedge clk) begin
      #2;
      if (!strap_en_o && p_strap)  t_strap_fall = cyc;
      if (cfg_drv_o && !p_cfg)     t_cfg_rise   = cyc;
      if (!cfg_drv_o && p_cfg)     t_cfg_fall   = cyc;
      if (cpu_rst_n_o && !p_cpu)   t_cpu_rise   = cyc;
      if (!cpu_rst_n_o && p_cpu)   t_cpu_fall   = cyc;
      if (arr_busy_o && !p_arr)    t_arr_rise   = cyc;
      if (!arr_busy_o && p_arr)    t_arr_fall   = cyc;
      if (done_pulse_o) begin t_done = cyc; n_done++; end
      p_strap = strap_en_o; p_cfg = cfg_drv_o; p_cpu = cpu_rst_n_o; p_arr = arr_busy_o;
   end

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_to(int c);
      while (cyc < c) @(negedge clk);
   endtask

   function automatic int exp_release(int plat_at, int link_at);
      int base = plat_at + LAT + SETUP;
      return (link_at < 0) ? base : link_at + 1;
   endfunction

   task automatic clear_times();
      t_strap_fall = -1; t_cfg_rise = -1; t_cfg_fall = -1; t_cpu_rise = -1;
      t_cpu_fall = -1; t_arr_rise = -1; t_arr_fall = -1; t_done = -1; n_done = 0;
   endtask

   // R1..R4: power loss, then power-good and strap capture
   task automatic power_up();
      logic [W-1:0] s;
      int n0;
      @(negedge clk);
      pwr_ok_i = 1'b0; plat_rst_n_i = 1'b0; link_done_i = 1'b0;
      #1;
      chk("R1 strap_en", int'(strap_en_o), 1);
      chk("R1 strap_q",  int'(strap_q_o), 0);
      chk("R1 cfg_drv",  int'(cfg_drv_o), 0);
      chk("R1 cpu_rst_n", int'(cpu_rst_n_o), 0);
      chk("R1 arr_busy", int'(arr_busy_o | done_pulse_o), 0);
      repeat (3) @(negedge clk);
      clear_times();
      s = W'($urandom);
      strap_i = s;
      n0 = cyc;
      pwr_ok_i = 1'b1;
      wait_to(n0 + LAT + DLY + 2);
      chk("R2 R3 strap_en fall", t_strap_fall, n0 + LAT);
      chk("R3 strap capture", int'(strap_q_o), int'(s));
      chk("R4 cfg rise", t_cfg_rise, n0 + LAT + DLY);
      chk("R4 cpu held", int'(cpu_rst_n_o), 0);
      strap_i = ~s;
      repeat (2) @(negedge clk);
      chk("R3 strap ignored", int'(strap_q_o), int'(s));
   endtask

   // full sequence; glitch>0 drives a short assertion inside the lockout
   task automatic run_case(bit late_link, int glitch);
      int p, d, rel, m;
      power_up();
      link_done_i = !late_link;
      p = cyc;
      plat_rst_n_i = 1'b1;
      if (glitch > 0) begin
         wait_to(p + glitch);
         plat_rst_n_i = 1'b0;
         repeat (3) @(negedge clk);
         plat_rst_n_i = 1'b1;
      end
      d = -1;
      if (late_link) begin
         d = p + LAT + SETUP + 5 + int'($urandom % 20);
         wait_to(d);
         chk("R6 waits for link", int'(cpu_rst_n_o), 0);
         link_done_i = 1'b1;
      end
      rel = exp_release(p, d);
      wait_to(rel + DONE + 3);
      chk("R2 R7 busy start", t_arr_rise, p + LAT);
      chk("R7 busy end", t_arr_fall, p + LAT + ARR);
      chk(glitch > 0 ? "R11 release kept" : "R5 R6 release", t_cpu_rise, rel);
      chk("R8 drive hold", t_cfg_fall, rel + HOLD);
      chk("R9 done time", t_done, rel + DONE);
      chk("R9 done single", n_done, 1);
      m = cyc;
      plat_rst_n_i = 1'b0;
      wait_to(m + LAT + 1);
      chk("R10 cpu reset", t_cpu_fall, m + LAT);
      chk("R10 drive same cycle", t_cfg_rise, m + LAT);
   endtask

   // R10: assertion exactly at the lockout limit is accepted during setup
   task automatic boundary_case();
      int p;
      power_up();
      link_done_i = 1'b1;
      p = cyc;
      plat_rst_n_i = 1'b1;
      wait_to(p + RETRIG);
      plat_rst_n_i = 1'b0;
      wait_to(p + LAT + SETUP + 5);
      chk("R10 busy cut", t_arr_fall, p + RETRIG + LAT);
      chk("R10 stays in reset", int'(cpu_rst_n_o), 0);
      chk("R10 drive on", int'(cfg_drv_o), 1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      run_case(1'b0, 0);
      run_case(1'b1, RETRIG - 1);
      boundary_case();
      for (int i = 0; i < 6; i++) begin
         run_case(1'($urandom % 2),
                  ($urandom % 3 == 0) ? 0 : 1 + int'($urandom % (RETRIG - 1)));
      end
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule